// File: doc/BRIEF.md
# Fan Level Controller

This block turns a sampled core temperature into a fan speed level between 0 and 10, where each level is one tenth of full speed. It is given a 16-bit temperature word, a signed value scaled by 256, along with an update strobe. On each accepted strobe it looks up an 11-entry threshold table and moves the level up or down by one step per clock until the move rule no longer applies. It then pulses an update-done output.

The move rule has wide hysteresis. The level climbs past every threshold the temperature already meets. It only falls once the temperature is below the threshold two entries under the current level. The threshold table can be rewritten at any time the block is idle, and it resets to 30 through 80 degrees in 5-degree steps. A sticky over-temperature flag and a 10-slot PWM fan drive are kept beside the level. The level and the flag are also presented in two fixed-layout status words.

Top module: `fan_level_ctrl`

## Requirements
- R1: After a synchronous reset the level is 3, the over-temperature flag is 0, the done pulse and busy are low, and the threshold table holds 30 + 5*i at entry i (i = 0..10).
- R2: On an accepted strobe the integer temperature is bits 15:8 of the temperature word. Fraction bits 7:0 are discarded, and a word with bit 15 set (negative) is treated as 0.
- R3: If the temperature is at least table[level], the level goes up by one per clock while level < 10 and temperature >= table[level+1].
- R4: Otherwise the level goes down by one per clock while level > 1 and temperature < table[level-2]. A temperature between table[level-2] and table[level] leaves the level unchanged.
- R5: Busy is high from the clock after the strobe is accepted until the clock on which no step applies. On that clock busy falls and the done pulse is high for exactly one cycle. The level changes only while busy.
- R6: A strobe that arrives while busy has no effect on the level or on the timing of the current update.
- R7: A table write with address 0..10 replaces that entry from the next clock. A write to address 11..15 changes no entry.
- R8: The over-temperature flag is set by an over-temperature input and stays set until a clear input. When both arrive together, set wins.
- R9: The PWM output repeats every 10 clocks and is high for as many of those clocks as the level. The count starts at the first clock after reset.
- R10: The fan word carries the level in bits 11:8 and zero elsewhere. The monitor word carries the flag in bit 15 and zero elsewhere.
- R11: The level never exceeds 10. The level used for evaluation is clamped to 10 before use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | Update strobe; samples temp_word when idle |
| temp_word | input | 16 | Temperature, signed, scaled by 256 |
| tbl_we | input | 1 | Threshold table write enable |
| tbl_addr | input | 4 | Threshold table entry index |
| tbl_wdata | input | 8 | Threshold value in whole degrees |
| ovt_in | input | 1 | Over-temperature event, sets the flag |
| ovt_clr | input | 1 | Clears the over-temperature flag |
| fan_level | output | 4 | Current fan level 0..10 |
| busy | output | 1 | Update in progress |
| upd_done | output | 1 | One-cycle pulse at the end of an update |
| pwm_out | output | 1 | Fan drive, 10-slot period |
| fan_word | output | 16 | Level in bits 11:8 |
| mon_word | output | 16 | Over-temperature flag in bit 15 |

## Verification
The properties assume the table is not written while an update is in progress. They also assume the level only begins from reset or from a finished update, so each busy clock moves it by at most one step. The stimulus keeps table writes and flag events in idle gaps of at least a dozen clocks after every strobe. The one deliberate exception is a second strobe issued on the clock after the first, which tests the rule that a strobe is ignored while busy. Temperatures cover positive values with and without fraction bits, negative words, and values exactly on a threshold. They are run against both the default table and a reloaded table.

// File: rtl/fan_pkg.sv
package fan_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_STEP = 1'b1
  } step_st_t;

  function automatic logic [7:0] dflt_thresh(input int idx, input int base, input int step);
    return 8'(base + step * idx);
  endfunction

endpackage

// File: rtl/fan_thresh_tbl.sv
module fan_thresh_tbl #(
  parameter int ENTRIES = 11,
  parameter int TW      = 8,
  parameter int AW      = 4,
  parameter int BASE    = 30,
  parameter int STEP    = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [TW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [TW-1:0] rdata
);
  import fan_pkg::*;

  logic [TW-1:0] mem_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) begin
        mem_q[i] <= TW'(dflt_thresh(i, BASE, STEP));
      end
    end else if (we && (int'(waddr) < ENTRIES)) begin
      mem_q[waddr] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (int'(raddr) == i) rdata = mem_q[i];
    end
  end

endmodule

// File: rtl/fan_level_step.sv
module fan_level_step #(
  parameter int LW       = 4,
  parameter int TW       = 8,
  parameter int LVL_MAX  = 10,
  parameter int LVL_INIT = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd_valid,
  input  logic [TW-1:0] temp_int,
  input  logic          temp_neg,
  input  logic [TW-1:0] tbl_rdata,
  output logic [LW-1:0] tbl_raddr,
  output logic [LW-1:0] level,
  output logic          busy,
  output logic          done
);
  import fan_pkg::*;

  localparam logic [LW-1:0] LMAX = LW'(LVL_MAX);

  step_st_t      st_q;
  logic [LW-1:0] lvl_q;
  logic [TW-1:0] t_q;
  logic          up_q;
  logic          done_q;

  logic [LW-1:0] lvl_clamped;
  logic [TW-1:0] t_in;
  logic          can_up;
  logic          can_dn;

  always_comb begin
    lvl_clamped = (lvl_q > LMAX) ? LMAX : lvl_q;
    t_in        = temp_neg ? '0 : temp_int;
    if (st_q == ST_IDLE) begin
      tbl_raddr = lvl_clamped;
    end else if (up_q) begin
      tbl_raddr = lvl_q + LW'(1);
    end else begin
      tbl_raddr = lvl_q - LW'(2);
    end
    can_up = (lvl_q < LMAX) && (t_q >= tbl_rdata);
    can_dn = (lvl_q > LW'(1)) && (t_q < tbl_rdata);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      lvl_q  <= LW'(LVL_INIT);
      t_q    <= '0;
      up_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (upd_valid) begin
            t_q   <= t_in;
            up_q  <= (t_in >= tbl_rdata);
            lvl_q <= lvl_clamped;
            st_q  <= ST_STEP;
          end
        end
        default: begin
          if (up_q && can_up) begin
            lvl_q <= lvl_q + LW'(1);
          end else if (!up_q && can_dn) begin
            lvl_q <= lvl_q - LW'(1);
          end else begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
      endcase
    end
  end

  assign level = lvl_q;
  assign busy  = (st_q == ST_STEP);
  assign done  = done_q;

endmodule

// File: rtl/fan_pwm.sv
module fan_pwm #(
  parameter int LW     = 4,
  parameter int PERIOD = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] level,
  output logic          pwm
);
  localparam int SW = $clog2(PERIOD);

  logic [SW-1:0] slot_q;
  logic          pwm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
      pwm_q  <= 1'b0;
    end else begin
      pwm_q  <= (int'(slot_q) < int'(level));
      slot_q <= (int'(slot_q) == PERIOD - 1) ? '0 : slot_q + SW'(1);
    end
  end

  assign pwm = pwm_q;

endmodule

// File: rtl/fan_ovt_flag.sv
module fan_ovt_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_in,
  input  logic clr_in,
  output logic flag
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst)         flag_q <= 1'b0;
    else if (set_in) flag_q <= 1'b1;
    else if (clr_in) flag_q <= 1'b0;
  end

  assign flag = flag_q;

endmodule

// File: rtl/fan_level_ctrl.sv
module fan_level_ctrl #(
  parameter int TEMP_W   = 16,
  parameter int TW       = 8,
  parameter int LVL_MAX  = 10,
  parameter int LVL_INIT = 3,
  parameter int T_BASE   = 30,
  parameter int T_STEP   = 5,
  parameter int PWM_SLOTS = 10,
  parameter int WORD_W   = 16,
  parameter int LVL_LSB  = 8,
  parameter int OVT_BIT  = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_valid,
  input  logic [TEMP_W-1:0] temp_word,
  input  logic              tbl_we,
  input  logic [3:0]        tbl_addr,
  input  logic [TW-1:0]     tbl_wdata,
  input  logic              ovt_in,
  input  logic              ovt_clr,
  output logic [3:0]        fan_level,
  output logic              busy,
  output logic              upd_done,
  output logic              pwm_out,
  output logic [WORD_W-1:0] fan_word,
  output logic [WORD_W-1:0] mon_word
);
  localparam int ENTRIES = LVL_MAX + 1;
  localparam int LW      = $clog2(ENTRIES);
  localparam int FRAC_W  = TEMP_W - TW;

  logic [LW-1:0] tbl_raddr;
  logic [TW-1:0] tbl_rdata;
  logic [LW-1:0] level;
  logic          ovt_flag;
  logic          unused_frac;

  assign unused_frac = ^temp_word[FRAC_W-1:0];

  fan_thresh_tbl #(
    .ENTRIES(ENTRIES), .TW(TW), .AW(LW), .BASE(T_BASE), .STEP(T_STEP)
  ) u_tbl (
    .clk(clk), .rst(rst), .we(tbl_we), .waddr(tbl_addr), .wdata(tbl_wdata),
    .raddr(tbl_raddr), .rdata(tbl_rdata)
  );

  fan_level_step #(
    .LW(LW), .TW(TW), .LVL_MAX(LVL_MAX), .LVL_INIT(LVL_INIT)
  ) u_step (
    .clk(clk), .rst(rst), .upd_valid(upd_valid),
    .temp_int({1'b0, temp_word[TEMP_W-2:FRAC_W]}),
    .temp_neg(temp_word[TEMP_W-1]),
    .tbl_rdata(tbl_rdata), .tbl_raddr(tbl_raddr),
    .level(level), .busy(busy), .done(upd_done)
  );

  fan_pwm #(.LW(LW), .PERIOD(PWM_SLOTS)) u_pwm (
    .clk(clk), .rst(rst), .level(level), .pwm(pwm_out)
  );

  fan_ovt_flag u_ovt (
    .clk(clk), .rst(rst), .set_in(ovt_in), .clr_in(ovt_clr), .flag(ovt_flag)
  );

  always_comb begin
    fan_level = level;
    fan_word  = '0;
    fan_word[LVL_LSB +: LW] = level;
    mon_word  = '0;
    mon_word[OVT_BIT] = ovt_flag;
  end

endmodule

// File: rtl/fan_level_chk.sv
module fan_level_chk #(
  parameter int LVL_MAX = 10,
  parameter int MW      = 16,
  parameter int OVT_BIT = 15
) (
  input logic          clk,
  input logic          rst,
  input logic          ovt_in,
  input logic          ovt_clr,
  input logic          busy,
  input logic          upd_done,
  input logic [3:0]    fan_level,
  input logic [MW-1:0] mon_word
);

  AST_LEVEL_MAX: assert property (@(posedge clk) disable iff (rst)
    int'(fan_level) <= LVL_MAX); // R11

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    upd_done |=> !upd_done); // R5

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    upd_done |-> !busy && $past(busy)); // R5

  AST_IDLE_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(fan_level)); // R5

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    busy |=> (fan_level == $past(fan_level)) ||
             (fan_level == $past(fan_level) + 4'd1) ||
             (fan_level + 4'd1 == $past(fan_level))); // R5

  AST_OVT_SET: assert property (@(posedge clk) disable iff (rst)
    ovt_in |=> mon_word[OVT_BIT]); // R8

  AST_OVT_STICKY: assert property (@(posedge clk) disable iff (rst)
    mon_word[OVT_BIT] && !ovt_clr |=> mon_word[OVT_BIT]); // R8

endmodule

bind fan_level_ctrl fan_level_chk #(
  .LVL_MAX(LVL_MAX), .MW(WORD_W), .OVT_BIT(OVT_BIT)
) u_chk (
  .clk(clk), .rst(rst), .ovt_in(ovt_in), .ovt_clr(ovt_clr), .busy(busy),
  .upd_done(upd_done), .fan_level(fan_level), .mon_word(mon_word)
);

// File: tb/tb_fan_level_ctrl.sv
module tb_fan_level_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        upd_valid = 1'b0;
  logic [15:0] temp_word = '0;
  logic        tbl_we = 1'b0;
  logic [3:0]  tbl_addr = '0;
  logic [7:0]  tbl_wdata = '0;
  logic        ovt_in = 1'b0;
  logic        ovt_clr = 1'b0;
  logic [3:0]  fan_level;
  logic        busy, upd_done, pwm_out;
  logic [15:0] fan_word, mon_word;

  always #2.5 clk = ~clk;

  fan_level_ctrl dut (
    .clk(clk), .rst(rst), .upd_valid(upd_valid), .temp_word(temp_word),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .ovt_in(ovt_in), .ovt_clr(ovt_clr), .fan_level(fan_level), .busy(busy),
    .upd_done(upd_done), .pwm_out(pwm_out), .fan_word(fan_word), .mon_word(mon_word)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit cmp_en   = 0;
  bit finished = 0;

  // Behavioural reference
  int m_tbl [11];
  int m_lvl, m_t, m_slot;
  bit m_busy, m_up, m_done, m_ovt, m_pwm;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 11; i++) m_tbl[i] = 30 + 5 * i;
      m_lvl = 3; m_t = 0; m_slot = 0;
      m_busy = 0; m_up = 0; m_done = 0; m_ovt = 0; m_pwm = 0;
    end else begin
      m_done = 0;
      m_pwm  = (m_slot < m_lvl);
      m_slot = (m_slot + 1) % 10;
      if (m_busy) begin
        if (m_up && m_lvl < 10 && m_t >= m_tbl[m_lvl + 1]) m_lvl++;
        else if (!m_up && m_lvl > 1 && m_t < m_tbl[m_lvl - 2]) m_lvl--;
        else begin m_busy = 0; m_done = 1; end
      end else if (upd_valid) begin
        m_t    = temp_word[15] ? 0 : int'(temp_word[15:8]);
        m_lvl  = (m_lvl > 10) ? 10 : m_lvl;
        m_up   = (m_t >= m_tbl[m_lvl]);
        m_busy = 1;
      end
      if (tbl_we && tbl_addr <= 4'd10) m_tbl[tbl_addr] = int'(tbl_wdata);
      if (ovt_in) m_ovt = 1;
      else if (ovt_clr) m_ovt = 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !finished) begin
      chk("R2 R3 R4 R7 R11 fan_level", int'(fan_level), m_lvl);
      chk("R5 R6 busy", int'(busy), int'(m_busy));
      chk("R5 upd_done", int'(upd_done), int'(m_done));
      chk("R9 pwm_out", int'(pwm_out), int'(m_pwm));
      chk("R10 fan_word", int'(fan_word), m_lvl << 8);
      chk("R8 R10 mon_word", int'(mon_word), int'(m_ovt) << 15);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic update(input logic [15:0] w);
    @(negedge clk);
    upd_valid = 1'b1; temp_word = w;
    @(negedge clk);
    upd_valid = 1'b0;
    idle(14);
  endtask

  task automatic wr_tbl(input int a, input int v);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = 4'(a); tbl_wdata = 8'(v);
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    cmp_en = 1;
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 reset level", int'(fan_level), 3);
    chk("R1 reset flag", int'(mon_word), 0);
    chk("R1 reset done", int'(upd_done), 0);
    idle(25);                   // R9: PWM at level 3
    update(16'h2F40);           // R3: 47 -> stays 3
    update(16'h3E00);           // R3: 62 -> 6
    update(16'h3900);           // R4: 57 inside band -> 6
    update(16'h2A80);           // R4: 42 -> 4
    update(16'h8000);           // R2: negative -> 1
    update(16'h2DFF);           // R2: 45.99 -> 45
    update(16'h5A00);           // R3 R11: 90 -> 10
    update(16'h5000);           // R4: 80 on threshold -> 10
    // R6: second strobe while busy ignored
    @(negedge clk); upd_valid = 1'b1; temp_word = 16'h1400;
    @(negedge clk); temp_word = 16'h6400;
    @(negedge clk); upd_valid = 1'b0;
    idle(14);
    // R7: reload table, out-of-range write ignored
    for (int i = 0; i < 11; i++) wr_tbl(i, 20 + 4 * i);
    wr_tbl(13, 0);
    wr_tbl(15, 200);
    idle(3);
    update(16'h2900);           // 41 with new table
    update(16'h3C00);           // 60 -> 10
    update(16'h1800);           // 24
    update(16'h0000);           // 0 -> 1
    idle(22);                   // R9 at level 1
    // R8: sticky flag
    @(negedge clk); ovt_in = 1'b1;
    @(negedge clk); ovt_in = 1'b0;
    idle(4);
    @(negedge clk); ovt_clr = 1'b1;
    @(negedge clk); ovt_clr = 1'b0;
    idle(2);
    @(negedge clk); ovt_in = 1'b1; ovt_clr = 1'b1;
    @(negedge clk); ovt_in = 1'b0; ovt_clr = 1'b0;
    idle(4);
    // R1: reset restores defaults
    @(negedge clk); rst = 1'b1;
    idle(2);
    @(negedge clk); rst = 1'b0;
    update(16'h3700);           // 55 on default table -> 5
    idle(5);
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

endmodule